// File: doc/BRIEF.md
# Dual-Speed 1-Wire Bus Master

This block drives one open-drain 1-Wire data line. It pulls the line low through an output enable and reads the line back through a synchronized input. A user-side command port starts one operation at a time: a bus reset with presence detection, a single-bit write, or a single-bit read. A speed select picks either the regular or the overdrive timing profile for each operation. The chosen profile is latched when the command is accepted, so every phase of that operation keeps to one profile.

The block holds `busy` high for the whole operation, including the recovery gap that follows it. It reports two results. The presence flag records whether some device pulled the line low inside the response window after the reset pulse. The read bit records the level of the line at the read sample point. All delays are computed from the `CLK_HZ` parameter, which gives the clock frequency. Byte framing, CRC, ROM commands and search belong to the logic above this block.

Top module: `ow_master`

## Requirements
- R1: A reset command (`cmdOp` = 0) pulls the line low for 500 µs at regular speed and for 64 µs at overdrive speed. At regular speed the pulse is long enough for every device and short enough that pulse plus rise time stays under 960 µs.
- R2: A reset operation keeps `busy` high for 1000 µs at regular speed and 120 µs at overdrive speed, measured from the start of the low pulse. This is the pulse plus a released wait of 500 µs or 56 µs. Every operation starts with the line pulled low in the first cycle after acceptance.
- R3: `presence` becomes 1 when the synchronized line is low 70 µs (regular) or 8 µs (overdrive) after the reset pulse ends, and becomes 0 otherwise. Only a reset operation changes it.
- R4: A write command (`cmdOp` = 1) with `cmdBit` = 1 pulls the line low for 6 µs (regular) or 1 µs (overdrive).
- R5: A write command with `cmdBit` = 0 pulls the line low for 60 µs (regular) or 6 µs (overdrive).
- R6: A read command (`cmdOp` = 2) pulls the line low for 6 µs (regular) or 1 µs (overdrive). `readBit` takes the synchronized line level 13 µs (regular) or 1.5 µs (overdrive) after the slot starts. Only a read operation changes it.
- R7: Each write or read slot keeps `busy` high for 70 µs (regular) or 10 µs (overdrive). This is the time slot plus a released recovery gap of at least 1 µs.
- R8: A command presented while `busy` is high is ignored. It neither lengthens nor alters the running operation.
- R9: The level of `overdrive` is latched when a command is accepted. Changing it during an operation does not change that operation's timing.
- R10: After reset, `owOe`, `busy`, `presence` and `readBit` are all 0.
- R11: Command code 3 is a no-operation. It leaves `busy` low and the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, accepted when `busy` is low |
| cmdOp | input | 2 | 0 reset, 1 write, 2 read, 3 no-operation |
| cmdBit | input | 1 | Bit value for a write |
| overdrive | input | 1 | 1 selects overdrive timing, latched at accept |
| owIn | input | 1 | Line level read back from the bus |
| owOe | output | 1 | 1 pulls the bus line low |
| busy | output | 1 | Operation in progress, including recovery |
| presence | output | 1 | Result of the last reset |
| readBit | output | 1 | Result of the last read slot |

## Verification
Each operation is run at both speeds against a bench slave model, with the low-pulse and busy lengths counted in cycles. Resets are run with a responding slave and with no slave, which shows that the presence sample falls inside the response window. Reads are run with a slave answering 0, which stretches the low, and with a slave answering 1, which leaves the line alone; together they show where the read sample point sits relative to the master pulse. Interleaving writes, reads and resets checks that each result flag changes only under its own operation. Directed cases inject a command and a speed flip mid-operation, and issue the no-operation code.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } owOp_e;

  // control -> datapath
  typedef struct packed {
    logic load;     // latch command, clear phase timer
    logic run;      // advance phase timer
    logic pullLow;  // drive the line low
    logic capture;  // take the sample for the latched operation
  } owStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lowEnd;
    logic sampleHit;
    logic opEnd;
  } owFlags_t;

  function automatic int unsigned nsToCycles(longint unsigned clkHz, longint unsigned ns);
    longint unsigned c;
    c = ((clkHz / 64'd1000) * ns) / 64'd1000000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/ow_datapath.sv
module ow_datapath
  import ow_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  owStrobe_t strobe,
  input  logic [1:0] cmdOp,
  input  logic      cmdBit,
  input  logic      overdrive,
  input  logic      lineIn,
  output owFlags_t  flags,
  output logic      lineOe,
  output logic      presence,
  output logic      readBit
);

  // regular profile
  localparam int unsigned R_RST_LOW  = nsToCycles(CLK_HZ, 500_000);
  localparam int unsigned R_RST_WAIT = nsToCycles(CLK_HZ, 500_000);
  localparam int unsigned R_PRES     = nsToCycles(CLK_HZ, 70_000);
  localparam int unsigned R_W1       = nsToCycles(CLK_HZ, 6_000);
  localparam int unsigned R_W0       = nsToCycles(CLK_HZ, 60_000);
  localparam int unsigned R_RD       = nsToCycles(CLK_HZ, 6_000);
  localparam int unsigned R_SMP      = nsToCycles(CLK_HZ, 13_000);
  localparam int unsigned R_SLOT     = nsToCycles(CLK_HZ, 70_000);
  // overdrive profile
  localparam int unsigned O_RST_LOW  = nsToCycles(CLK_HZ, 64_000);
  localparam int unsigned O_RST_WAIT = nsToCycles(CLK_HZ, 56_000);
  localparam int unsigned O_PRES     = nsToCycles(CLK_HZ, 8_000);
  localparam int unsigned O_W1       = nsToCycles(CLK_HZ, 1_000);
  localparam int unsigned O_W0       = nsToCycles(CLK_HZ, 6_000);
  localparam int unsigned O_RD       = nsToCycles(CLK_HZ, 1_000);
  localparam int unsigned O_SMP      = nsToCycles(CLK_HZ, 1_500);
  localparam int unsigned O_SLOT     = nsToCycles(CLK_HZ, 10_000);

  localparam int unsigned MAX_END = R_RST_LOW + R_RST_WAIT;
  localparam int          TW      = $clog2(MAX_END + 1);

  owOp_e       opQ;
  logic        bitQ;
  logic        odQ;
  logic [TW-1:0] timer;
  logic [TW-1:0] lowLen;
  logic [TW-1:0] sampleAt;
  logic [TW-1:0] endAt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic        lineSync;

  // input synchronizer, idle line reads high
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= lineIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate
  assign lineSync = syncQ[SYNC_STAGES-1];

  // command latch and phase timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_NONE;
      bitQ  <= 1'b0;
      odQ   <= 1'b0;
      timer <= '0;
    end else if (strobe.load) begin
      opQ   <= owOp_e'(cmdOp);
      bitQ  <= cmdBit;
      odQ   <= overdrive;
      timer <= '0;
    end else if (strobe.run) begin
      timer <= timer + 1'b1;
    end
  end

  // per-operation thresholds from the latched profile
  always_comb begin
    lowLen   = TW'(R_RD);
    sampleAt = TW'(R_SMP);
    endAt    = odQ ? TW'(O_SLOT) : TW'(R_SLOT);
    unique case (opQ)
      OP_RESET: begin
        lowLen   = odQ ? TW'(O_RST_LOW) : TW'(R_RST_LOW);
        sampleAt = odQ ? TW'(O_RST_LOW + O_PRES) : TW'(R_RST_LOW + R_PRES);
        endAt    = odQ ? TW'(O_RST_LOW + O_RST_WAIT) : TW'(R_RST_LOW + R_RST_WAIT);
      end
      OP_WRITE: begin
        if (bitQ) lowLen = odQ ? TW'(O_W1) : TW'(R_W1);
        else      lowLen = odQ ? TW'(O_W0) : TW'(R_W0);
        sampleAt = '1;
      end
      OP_READ: begin
        lowLen   = odQ ? TW'(O_RD) : TW'(R_RD);
        sampleAt = odQ ? TW'(O_SMP) : TW'(R_SMP);
      end
      default: begin
        lowLen   = TW'(1);
        sampleAt = '1;
        endAt    = TW'(2);
      end
    endcase
  end

  assign flags.lowEnd    = (timer == lowLen - 1'b1);
  assign flags.sampleHit = (timer == sampleAt);
  assign flags.opEnd     = (timer == endAt - 1'b1);

  // results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presence <= 1'b0;
      readBit  <= 1'b0;
    end else if (strobe.capture) begin
      if (opQ == OP_RESET)     presence <= ~lineSync;
      else if (opQ == OP_READ) readBit  <= lineSync;
    end
  end

  assign lineOe = strobe.pullLow;

endmodule

// File: rtl/ow_ctrl.sv
module ow_ctrl
  import ow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  owFlags_t   flags,
  output owStrobe_t  strobe,
  output logic       busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_RELEASED} owState_e;

  owState_e state;
  owState_e stateNext;
  logic     accept;

  assign accept = cmdValid && (state == ST_IDLE) && (owOp_e'(cmdOp) != OP_NONE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (accept)      stateNext = ST_LOW;
      ST_LOW:      if (flags.lowEnd) stateNext = ST_RELEASED;
      ST_RELEASED: if (flags.opEnd)  stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load    = accept;
    strobe.run     = (state != ST_IDLE);
    strobe.pullLow = (state == ST_LOW);
    strobe.capture = (state != ST_IDLE) && flags.sampleHit;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       overdrive,
  input  logic       owIn,
  output logic       owOe,
  output logic       busy,
  output logic       presence,
  output logic       readBit
);

  owStrobe_t strobe;
  owFlags_t  flags;

  ow_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .flags    (flags),
    .strobe   (strobe),
    .busy     (busy)
  );

  ow_datapath #(
    .CLK_HZ      (CLK_HZ),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdOp     (cmdOp),
    .cmdBit    (cmdBit),
    .overdrive (overdrive),
    .lineIn    (owIn),
    .flags     (flags),
    .lineOe    (owOe),
    .presence  (presence),
    .readBit   (readBit)
  );

endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       owOe,
  input logic       busy,
  input logic       presence,
  input logic       readBit
);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !owOe);

  // R11
  noop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp == 2'd3) |=> !busy);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp != 2'd3) |=> (busy && owOe));

  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(owOe) |-> $past(cmdValid && !busy));

  // R3
  pres_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(presence));

  // R6
  read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(readBit));

endmodule

bind ow_master ow_master_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .owOe     (owOe),
  .busy     (busy),
  .presence (presence),
  .readBit  (readBit)
);

// File: tb/ow_master_tb_top.sv
module ow_master_tb_top;

  // 4 MHz nominal: one microsecond is four cycles
  localparam longint unsigned TB_HZ = 4_000_000;

  typedef struct packed {
    logic [1:0]  op;
    logic        bitv;
    logic        od;
    logic        slv;      // reset: slave present; read: slave answers this bit
    logic [15:0] expLow;
    logic [15:0] expBusy;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 1'b0, 1'b0, 1'b1, 16'd2000, 16'd4000},
    '{2'd1, 1'b1, 1'b0, 1'b0, 16'd24,   16'd280},
    '{2'd2, 1'b0, 1'b0, 1'b0, 16'd24,   16'd280},
    '{2'd2, 1'b0, 1'b0, 1'b1, 16'd24,   16'd280},
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'd240,  16'd280},
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'd2000, 16'd4000},
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'd4,    16'd40},
    '{2'd2, 1'b0, 1'b1, 1'b0, 16'd4,    16'd40},
    '{2'd2, 1'b0, 1'b1, 1'b1, 16'd4,    16'd40},
    '{2'd1, 1'b0, 1'b1, 1'b0, 16'd24,   16'd40},
    '{2'd0, 1'b0, 1'b1, 1'b1, 16'd256,  16'd480},
    '{2'd0, 1'b0, 1'b1, 1'b0, 16'd256,  16'd480}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd3;
  logic cmdBit = 1'b0;
  logic overdrive = 1'b0;
  logic owOe, busy, presence, readBit;
  logic owLine;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // slave model state
  logic [1:0] curOp = 2'd3;
  logic curSlv = 1'b0;
  logic curOd = 1'b0;
  logic oePrev = 1'b0;
  int slvHold = 0;
  int slvDelay = 0;
  int slvLen = 0;
  logic slvPull;

  always #2 clk = ~clk;

  ow_master #(.CLK_HZ(TB_HZ)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBit(cmdBit), .overdrive(overdrive), .owIn(owLine),
    .owOe(owOe), .busy(busy), .presence(presence), .readBit(readBit)
  );

  assign slvPull = (slvHold > 0) || (slvLen > 0);
  assign owLine  = !(owOe || slvPull);

  always @(posedge clk) begin
    oePrev <= owOe;
    if (owOe && !oePrev && curOp == 2'd2 && !curSlv)
      slvHold <= curOd ? 12 : 120;
    else if (slvHold > 0)
      slvHold <= slvHold - 1;
    if (!owOe && oePrev && curOp == 2'd0 && curSlv)
      slvDelay <= curOd ? 12 : 120;
    else if (slvDelay > 1)
      slvDelay <= slvDelay - 1;
    else if (slvDelay == 1) begin
      slvDelay <= 0;
      slvLen   <= curOd ? 64 : 480;
    end else if (slvLen > 0)
      slvLen <= slvLen - 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one command, optionally disturb inputs at busy cycle injAt
  task automatic runOp(input logic [1:0] op, input logic bitv, input logic od,
                       input logic slv, input int injAt, input logic injCmd,
                       output int lowCnt, output int busyCnt);
    @(negedge clk);
    curOp = op; curSlv = slv; curOd = od;
    cmdValid = 1'b1; cmdOp = op; cmdBit = bitv; overdrive = od;
    @(negedge clk);
    cmdValid = 1'b0;
    lowCnt = 0; busyCnt = 0;
    while (busy && busyCnt < 10000) begin
      if (busyCnt == injAt) begin
        cmdValid = injCmd; cmdOp = 2'd2; overdrive = !od;
      end else if (busyCnt == injAt + 1) begin
        cmdValid = 1'b0;
      end
      busyCnt++;
      if (owOe) lowCnt++;
      @(negedge clk);
    end
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=idle");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lowCnt, busyCnt;
    logic expPres, expRd;
    expPres = 1'b0; expRd = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(owOe == 1'b0,     "R10 owOe",     int'(owOe), 0);
    check(busy == 1'b0,     "R10 busy",     int'(busy), 0);
    check(presence == 1'b0, "R10 presence", int'(presence), 0);
    check(readBit == 1'b0,  "R10 readBit",  int'(readBit), 0);

    // R11 no-operation code
    cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b0, "R11 busy after no-op", int'(busy), 0);
    check(owOe == 1'b0, "R11 owOe after no-op", int'(owOe), 0);

    // vector table
    foreach (VECS[i]) begin
      vec_t v;
      string lowReq, busyReq;
      v = VECS[i];
      runOp(v.op, v.bitv, v.od, v.slv, -10, 1'b0, lowCnt, busyCnt);
      if (v.op == 2'd0) begin expPres = v.slv; lowReq = "R1 reset low"; busyReq = "R2 reset busy"; end
      else begin
        busyReq = "R7 slot busy";
        if (v.op == 2'd2) begin expRd = v.slv; lowReq = "R6 read low"; end
        else lowReq = v.bitv ? "R4 write-one low" : "R5 write-zero low";
      end
      check(lowCnt == int'(v.expLow),   lowReq,  lowCnt,  int'(v.expLow));
      check(busyCnt == int'(v.expBusy), busyReq, busyCnt, int'(v.expBusy));
      check(presence == expPres, "R3 presence", int'(presence), int'(expPres));
      check(readBit == expRd,    "R6 readBit",  int'(readBit),  int'(expRd));
    end

    // R8 command while busy is ignored
    runOp(2'd1, 1'b1, 1'b0, 1'b0, 10, 1'b1, lowCnt, busyCnt);
    check(lowCnt == 24,   "R8 low with injected cmd",  lowCnt, 24);
    check(busyCnt == 280, "R8 busy with injected cmd", busyCnt, 280);
    @(negedge clk);
    check(busy == 1'b0,   "R8 no queued op", int'(busy), 0);
    check(readBit == expRd, "R8 readBit untouched", int'(readBit), int'(expRd));

    // R9 speed flip mid-operation
    runOp(2'd1, 1'b0, 1'b0, 1'b0, 2, 1'b0, lowCnt, busyCnt);
    check(lowCnt == 240,  "R9 write-zero low after flip", lowCnt, 240);
    check(busyCnt == 280, "R9 busy after flip", busyCnt, 280);
    runOp(2'd0, 1'b0, 1'b1, 1'b1, 30, 1'b0, lowCnt, busyCnt);
    check(lowCnt == 256,  "R9 reset low after flip", lowCnt, 256);
    check(presence == 1'b1, "R9 presence after flip", int'(presence), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule